// File: doc/BRIEF.md
# Translation Base Select and Input-Range Check

This block runs first in a 64-bit page table walk. It receives the virtual address, the exception level of the access, the access type and the translation control settings for the two halves of the address space. The low half is walked from the low base register and the high half from the high base register. For each half the settings are a size field, a granule selector, a walk-disable bit and two tag-ignore bits. A host-extension enable and a large-address capability strap complete the inputs.

On a one-cycle `start` strobe the block finds the address bit that splits the two halves and picks the base register. It then derives the effective input-address size and the granule from the chosen half. It raises `fault` when that size is outside the limits the granule and the capability strap allow, when the address bits above that size do not match the chosen half, or when the exception level does not permit the walk. The results are registered and appear together with a one-cycle `done` pulse. The walker uses them to start the descriptor fetch or to report a translation fault.

Top module: `tva_walk_entry`

## Requirements
- R1: After reset `done`, `fault`, `base_hi`, `in_size` and `granule` are all zero. Every `start` produces exactly one `done` pulse on the next cycle, which carries that request's results. With no `start`, `done` is low on the next cycle.
- R2: `in_size` is 64 minus the size field of the selected half. `granule` reports that half's selector with the code 0 = 4KB, 1 = 16KB, 2 = 64KB. Selector code 3 is treated as 4KB and reported as 0.
- R3: The largest allowed input size is 52 when `lva_cap` is high and the 64KB granule is selected. In every other case it is 48. A larger size faults.
- R4: The smallest allowed input size is 17 for the 64KB granule and 16 for the other granules. A smaller size faults.
- R5: A probe half is found first. At EL0 and EL1, and at EL2 with host extension on, it is given by address bit 55. At EL2 with host extension off, and at EL3, it is always the low half. The top bit is 55 when the probe half's tag-ignore bit is set, unless the access is an instruction fetch and that half's fetch-tag-off bit is set. Otherwise the top bit is 63. `base_hi` is the address bit at the top bit, where 1 selects the high base register.
- R6: For the low half, address bits from the top bit down to bit `in_size` must all be 0. For the high half they must all be 1. Any other pattern faults.
- R7: At EL0 and EL1, a set walk-disable bit of the selected half faults even when the range checks pass. The other half's walk-disable bit has no effect.
- R8: At EL2 with host extension off, a high-half access faults and the low-half walk-disable bit is ignored. With host extension on, both halves are valid and each walk-disable bit applies to its own half.
- R9: At EL3 only the low half is valid. A high-half selection faults unconditionally, and the walk-disable bits are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request strobe |
| va | input | 64 | Virtual address |
| el | input | 2 | Exception level (0 to 3) |
| is_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| lo_size | input | 6 | Size field of the low half |
| hi_size | input | 6 | Size field of the high half |
| lo_gran | input | 2 | Granule selector of the low half |
| hi_gran | input | 2 | Granule selector of the high half |
| lo_walk_off | input | 1 | Walk-disable for the low half |
| hi_walk_off | input | 1 | Walk-disable for the high half |
| host_ext_en | input | 1 | Host extension enable at EL2 |
| lo_tag_ign | input | 1 | Tag-ignore enable for the low half |
| hi_tag_ign | input | 1 | Tag-ignore enable for the high half |
| lo_tag_fetch_off | input | 1 | Disables low-half tag-ignore for fetches |
| hi_tag_fetch_off | input | 1 | Disables high-half tag-ignore for fetches |
| lva_cap | input | 1 | Large input-address capability strap |
| done | output | 1 | Result valid pulse |
| fault | output | 1 | Range or permission fault |
| base_hi | output | 1 | 1 = high base register selected |
| in_size | output | 7 | Effective input-address size |
| granule | output | 2 | Granule code of the selected half |

## Verification
Several fault causes can arrive together in one request: a size-limit violation, a half-range mismatch and a walk-disable or level rule. Directed cases set a size beyond the limit on a non-matching address with walk-disable set. The bench checks that `fault` stays high and that `in_size` and `granule` still report the selected half. Tag-ignore and half selection also interact in a single request. Directed cases place a tag byte above bit 55 and flip `is_fetch` with the fetch-tag-off bit set, which must move the selection from bit 55 to bit 63 and turn the tag into a range fault. A long run of random requests, some back to back, is compared cycle by cycle against a behavioural model.

// File: rtl/tva_pkg.sv
package tva_pkg;

    typedef enum logic [1:0] {
        EL_0 = 2'd0,
        EL_1 = 2'd1,
        EL_2 = 2'd2,
        EL_3 = 2'd3
    } level_e;

    typedef enum logic [1:0] {
        GR_4K  = 2'd0,
        GR_16K = 2'd1,
        GR_64K = 2'd2
    } granule_e;

    function automatic granule_e decode_granule(input logic [1:0] code);
        case (code)
            2'd1:    return GR_16K;
            2'd2:    return GR_64K;
            default: return GR_4K;
        endcase
    endfunction

endpackage

// File: rtl/tva_topbit.sv
module tva_topbit #(
    parameter int VA_W  = 64,
    parameter int TAG_W = 8,
    localparam int IDX_W = $clog2(VA_W)
) (
    input  logic [VA_W-1:0]  va,
    input  tva_pkg::level_e  el,
    input  logic             is_fetch,
    input  logic             host_ext_en,
    input  logic             lo_tag_ign,
    input  logic             hi_tag_ign,
    input  logic             lo_tag_fetch_off,
    input  logic             hi_tag_fetch_off,
    output logic [IDX_W-1:0] top_idx,
    output logic             sel_hi
);
    import tva_pkg::*;

    localparam int TAG_TOP  = VA_W - TAG_W - 1;
    localparam int FULL_TOP = VA_W - 1;

    logic two_halves;
    logic probe_hi;
    logic tag_on;
    logic tag_fetch_off;

    always_comb begin
        two_halves    = (el == EL_0) || (el == EL_1) || ((el == EL_2) && host_ext_en);
        probe_hi      = two_halves ? va[TAG_TOP] : 1'b0;
        tag_on        = probe_hi ? hi_tag_ign : lo_tag_ign;
        tag_fetch_off = probe_hi ? hi_tag_fetch_off : lo_tag_fetch_off;
        if (tag_on && !(is_fetch && tag_fetch_off)) begin
            top_idx = IDX_W'(TAG_TOP);
        end else begin
            top_idx = IDX_W'(FULL_TOP);
        end
        sel_hi = va[top_idx];
    end

endmodule

// File: rtl/tva_limits.sv
module tva_limits #(
    parameter int IN_W      = 7,
    parameter int MAX_STD   = 48,
    parameter int MAX_LARGE = 52,
    parameter int MIN_STD   = 16,
    parameter int MIN_64K   = 17
) (
    input  tva_pkg::granule_e gran,
    input  logic              lva_cap,
    output logic [IN_W-1:0]   min_sz,
    output logic [IN_W-1:0]   max_sz
);
    import tva_pkg::*;

    always_comb begin
        if (lva_cap && (gran == GR_64K)) begin
            max_sz = IN_W'(MAX_LARGE);
        end else begin
            max_sz = IN_W'(MAX_STD);
        end
        if (gran == GR_64K) begin
            min_sz = IN_W'(MIN_64K);
        end else begin
            min_sz = IN_W'(MIN_STD);
        end
    end

endmodule

// File: rtl/tva_range.sv
module tva_range #(
    parameter int VA_W = 64,
    localparam int IDX_W = $clog2(VA_W),
    localparam int IN_W  = IDX_W + 1
) (
    input  logic [VA_W-1:0]  va,
    input  logic [IDX_W-1:0] top_idx,
    input  logic [IN_W-1:0]  size,
    input  logic             want_hi,
    output logic             mismatch
);
    logic [VA_W-1:0] in_field;
    logic [VA_W-1:0] wrong;

    for (genvar i = 0; i < VA_W; i++) begin : g_bit
        assign in_field[i] = (IN_W'(i) >= size) && (IDX_W'(i) <= top_idx);
        assign wrong[i]    = in_field[i] && (va[i] != want_hi);
    end

    assign mismatch = |wrong;

endmodule

// File: rtl/tva_walk_entry.sv
module tva_walk_entry #(
    parameter int VA_W      = 64,
    parameter int SZ_W      = 6,
    parameter int MAX_STD   = 48,
    parameter int MAX_LARGE = 52,
    parameter int MIN_STD   = 16,
    parameter int MIN_64K   = 17,
    localparam int IDX_W    = $clog2(VA_W),
    localparam int IN_W     = IDX_W + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [VA_W-1:0] va,
    input  logic [1:0]      el,
    input  logic            is_fetch,
    input  logic [SZ_W-1:0] lo_size,
    input  logic [SZ_W-1:0] hi_size,
    input  logic [1:0]      lo_gran,
    input  logic [1:0]      hi_gran,
    input  logic            lo_walk_off,
    input  logic            hi_walk_off,
    input  logic            host_ext_en,
    input  logic            lo_tag_ign,
    input  logic            hi_tag_ign,
    input  logic            lo_tag_fetch_off,
    input  logic            hi_tag_fetch_off,
    input  logic            lva_cap,
    output logic            done,
    output logic            fault,
    output logic            base_hi,
    output logic [IN_W-1:0] in_size,
    output logic [1:0]      granule
);
    import tva_pkg::*;

    typedef struct packed {
        logic            done;
        logic            fault;
        logic            hi;
        logic [IN_W-1:0] size;
        granule_e        gran;
    } result_t;

    result_t res_d, res_q;

    level_e          el_e;
    logic [IDX_W-1:0] top_idx;
    logic            sel_hi;
    logic [IN_W-1:0] eff_size;
    granule_e        sel_gran;
    logic [IN_W-1:0] min_sz;
    logic [IN_W-1:0] max_sz;
    logic            range_bad;
    logic            size_bad;
    logic            level_bad;

    assign el_e = level_e'(el);

    tva_topbit #(.VA_W(VA_W)) u_topbit (
        .va               (va),
        .el               (el_e),
        .is_fetch         (is_fetch),
        .host_ext_en      (host_ext_en),
        .lo_tag_ign       (lo_tag_ign),
        .hi_tag_ign       (hi_tag_ign),
        .lo_tag_fetch_off (lo_tag_fetch_off),
        .hi_tag_fetch_off (hi_tag_fetch_off),
        .top_idx          (top_idx),
        .sel_hi           (sel_hi)
    );

    always_comb begin
        if (sel_hi) begin
            eff_size = IN_W'(VA_W) - IN_W'(hi_size);
            sel_gran = decode_granule(hi_gran);
        end else begin
            eff_size = IN_W'(VA_W) - IN_W'(lo_size);
            sel_gran = decode_granule(lo_gran);
        end
    end

    tva_limits #(
        .IN_W      (IN_W),
        .MAX_STD   (MAX_STD),
        .MAX_LARGE (MAX_LARGE),
        .MIN_STD   (MIN_STD),
        .MIN_64K   (MIN_64K)
    ) u_limits (
        .gran    (sel_gran),
        .lva_cap (lva_cap),
        .min_sz  (min_sz),
        .max_sz  (max_sz)
    );

    tva_range #(.VA_W(VA_W)) u_range (
        .va       (va),
        .top_idx  (top_idx),
        .size     (eff_size),
        .want_hi  (sel_hi),
        .mismatch (range_bad)
    );

    always_comb begin
        size_bad = (eff_size > max_sz) || (eff_size < min_sz);
        case (el_e)
            EL_0, EL_1: level_bad = sel_hi ? hi_walk_off : lo_walk_off;
            EL_2:       level_bad = sel_hi ? (!host_ext_en || hi_walk_off)
                                           : (host_ext_en && lo_walk_off);
            default:    level_bad = sel_hi;
        endcase
    end

    always_comb begin
        res_d      = res_q;
        res_d.done = start;
        if (start) begin
            res_d.hi    = sel_hi;
            res_d.size  = eff_size;
            res_d.gran  = sel_gran;
            res_d.fault = size_bad || range_bad || level_bad;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign done    = res_q.done;
    assign fault   = res_q.fault;
    assign base_hi = res_q.hi;
    assign in_size = res_q.size;
    assign granule = res_q.gran;

    AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done); // R1
    AST_ABOVE_LARGE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (in_size > IN_W'(MAX_LARGE))) |-> fault); // R3
    AST_STD_MAX_NO_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !lva_cap) |=> (!(in_size > IN_W'(MAX_STD)) || fault)); // R3
    AST_BELOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (in_size < IN_W'(MIN_STD))) |-> fault); // R4
    AST_EL2_NOHOST_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (el == 2'd2) && !host_ext_en) |=> (!base_hi || fault)); // R8
    AST_EL3_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (el == 2'd3)) |=> (!base_hi || fault)); // R9

endmodule

// File: tb/tb_tva_walk_entry.sv
module tb_tva_walk_entry;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk;
    logic        rst_n;
    logic        start;
    logic [63:0] va;
    logic [1:0]  el;
    logic        is_fetch;
    logic [5:0]  lo_size, hi_size;
    logic [1:0]  lo_gran, hi_gran;
    logic        lo_walk_off, hi_walk_off;
    logic        host_ext_en;
    logic        lo_tag_ign, hi_tag_ign;
    logic        lo_tag_fetch_off, hi_tag_fetch_off;
    logic        lva_cap;
    logic        done, fault, base_hi;
    logic [6:0]  in_size;
    logic [1:0]  granule;

    int n_checks = 0;
    int n_fails  = 0;

    bit exp_done;
    bit exp_fault, exp_hi;
    int exp_size, exp_gran;

    tva_walk_entry dut (
        .clk(clk), .rst_n(rst_n), .start(start), .va(va), .el(el), .is_fetch(is_fetch),
        .lo_size(lo_size), .hi_size(hi_size), .lo_gran(lo_gran), .hi_gran(hi_gran),
        .lo_walk_off(lo_walk_off), .hi_walk_off(hi_walk_off), .host_ext_en(host_ext_en),
        .lo_tag_ign(lo_tag_ign), .hi_tag_ign(hi_tag_ign),
        .lo_tag_fetch_off(lo_tag_fetch_off), .hi_tag_fetch_off(hi_tag_fetch_off),
        .lva_cap(lva_cap), .done(done), .fault(fault), .base_hi(base_hi),
        .in_size(in_size), .granule(granule)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Behavioural reference built from the requirement text.
    task automatic model();
        bit two, probe, tg, tgoff, h;
        int top, field, gc, g, mx, mn, sz;
        bit f;
        two   = (el < 2) || (el == 2 && host_ext_en);
        probe = two ? va[55] : 1'b0;
        tg    = probe ? hi_tag_ign : lo_tag_ign;
        tgoff = probe ? hi_tag_fetch_off : lo_tag_fetch_off;
        top   = (tg && !(is_fetch && tgoff)) ? 55 : 63;
        h     = va[top];
        field = h ? int'(hi_size) : int'(lo_size);
        gc    = h ? int'(hi_gran) : int'(lo_gran);
        g     = (gc == 1) ? 1 : (gc == 2) ? 2 : 0;
        sz    = 64 - field;
        mx    = (lva_cap && g == 2) ? 52 : 48;
        mn    = (g == 2) ? 17 : 16;
        f     = (sz > mx) || (sz < mn);
        for (int i = sz; i <= top; i++) begin
            if (va[i] != h) f = 1'b1;
        end
        case (el)
            2'd0, 2'd1: f = f | (h ? hi_walk_off : lo_walk_off);
            2'd2: begin
                if (h) f = f | !host_ext_en | hi_walk_off;
                else   f = f | (host_ext_en & lo_walk_off);
            end
            default: if (h) f = 1'b1;
        endcase
        exp_fault = f;
        exp_hi    = h;
        exp_size  = sz;
        exp_gran  = g;
    endtask

    // Drive one cycle at a falling edge, compare after the next rising edge.
    task automatic step(input bit s, input string tag);
        start    = s;
        exp_done = s;
        if (s) model();
        @(negedge clk);
        check(tag, "R1 done", int'(done), int'(exp_done));
        if (exp_done) begin
            check(tag, "fault",         int'(fault),   int'(exp_fault));
            check(tag, "R5 base_hi",    int'(base_hi), int'(exp_hi));
            check(tag, "R2 in_size",    int'(in_size), exp_size);
            check(tag, "R2 granule",    int'(granule), exp_gran);
        end
    endtask

    task automatic defaults();
        va = '0; el = 2'd1; is_fetch = 1'b0;
        lo_size = 6'd16; hi_size = 6'd16; lo_gran = 2'd0; hi_gran = 2'd0;
        lo_walk_off = 1'b0; hi_walk_off = 1'b0; host_ext_en = 1'b0;
        lo_tag_ign = 1'b0; hi_tag_ign = 1'b0;
        lo_tag_fetch_off = 1'b0; hi_tag_fetch_off = 1'b0; lva_cap = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        defaults();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "reset done",    int'(done),    0);
        check("R1", "reset fault",   int'(fault),   0);
        check("R1", "reset base_hi", int'(base_hi), 0);
        check("R1", "reset size",    int'(in_size), 0);
        check("R1", "reset granule", int'(granule), 0);

        // R2: size and granule reporting
        defaults(); va = 64'h0000_1234_5678_9abc; step(1, "R2");
        lo_size = 6'd25; lo_gran = 2'd3; va = 64'h0000_0000_1234_5678; step(1, "R2");
        lo_gran = 2'd1; step(1, "R2");

        // R3: maximum size
        defaults(); lo_size = 6'd12; lo_gran = 2'd2; lva_cap = 1'b1; step(1, "R3");
        lva_cap = 1'b0; step(1, "R3");
        lva_cap = 1'b1; lo_gran = 2'd0; step(1, "R3");
        lo_size = 6'd15; lo_gran = 2'd2; step(1, "R3");
        lva_cap = 1'b0; lo_size = 6'd16; lo_gran = 2'd1; step(1, "R3");

        // R4: minimum size
        defaults(); lo_size = 6'd47; lo_gran = 2'd2; step(1, "R4");
        lo_size = 6'd48; step(1, "R4");
        lo_gran = 2'd0; step(1, "R4");
        lo_size = 6'd49; step(1, "R4");

        // R5: top bit moves with tag-ignore and the fetch override
        defaults(); hi_tag_ign = 1'b1; va = 64'h5AFF_FFFF_0000_1000; step(1, "R5");
        is_fetch = 1'b1; hi_tag_fetch_off = 1'b1; step(1, "R5");
        hi_tag_fetch_off = 1'b0; step(1, "R5");
        defaults(); lo_tag_ign = 1'b1; va = 64'hA500_0000_0000_2000; step(1, "R5");
        lo_tag_ign = 1'b0; step(1, "R5");

        // R6: half-range patterns
        defaults(); va = 64'h0004_0000_0000_0000; step(1, "R6");
        va = 64'hFFFF_8000_0000_0000; step(1, "R6");
        va = 64'hFFFE_8000_0000_0000; step(1, "R6");
        va = 64'hFFFF_FFFF_FFFF_F000; hi_size = 6'd12; hi_gran = 2'd2; lva_cap = 1'b1; step(1, "R6");
        va = 64'hFFEF_FFFF_FFFF_F000; step(1, "R6");

        // R7: walk-disable at EL0/EL1
        defaults(); el = 2'd0; lo_walk_off = 1'b1; va = 64'h0000_0000_0000_4000; step(1, "R7");
        lo_walk_off = 1'b0; hi_walk_off = 1'b1; step(1, "R7");
        va = 64'hFFFF_0000_0000_4000; step(1, "R7");

        // R8: EL2 host extension rules
        defaults(); el = 2'd2; va = 64'hFFFF_0000_0000_0000; step(1, "R8");
        va = 64'h0000_0000_0000_8000; lo_walk_off = 1'b1; step(1, "R8");
        host_ext_en = 1'b1; step(1, "R8");
        lo_walk_off = 1'b0; va = 64'hFFFF_0000_0000_8000; step(1, "R8");
        hi_walk_off = 1'b1; step(1, "R8");

        // R9: EL3 rules
        defaults(); el = 2'd3; va = 64'hFFFF_FFFF_FFFF_0000; step(1, "R9");
        va = 64'h0000_0000_0000_0040; lo_walk_off = 1'b1; hi_walk_off = 1'b1; step(1, "R9");
        lo_tag_ign = 1'b1; va = 64'h8000_0000_0000_0040; step(1, "R9");

        // Coinciding causes: size limit, range mismatch and walk-disable together
        defaults(); el = 2'd1; lo_size = 6'd10; lo_walk_off = 1'b1; va = 64'h0100_0000_0000_0000;
        step(1, "R3");

        // R1: back-to-back requests, then idle
        defaults(); va = 64'h0000_0000_0000_0100; step(1, "R1");
        va = 64'hFFFF_FFFF_0000_0100; step(1, "R1");
        step(0, "R1");
        step(0, "R1");

        // Random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            bit      h;
            int      k;
            logic [63:0] low;
            h   = 1'($urandom_range(0, 1));
            k   = $urandom_range(8, 60);
            low = {$urandom, $urandom};
            low = low & ((64'd1 << k) - 64'd1);
            va  = h ? (~((64'd1 << k) - 64'd1) | low) : low;
            if ($urandom_range(0, 3) == 0) va[63:56] = 8'($urandom);
            if ($urandom_range(0, 7) == 0) va[$urandom_range(0, 63)] ^= 1'b1;
            el = 2'($urandom);
            is_fetch = 1'($urandom);
            lo_size = 6'($urandom_range(8, 52));
            hi_size = 6'($urandom_range(8, 52));
            lo_gran = 2'($urandom); hi_gran = 2'($urandom);
            lo_walk_off = ($urandom_range(0, 5) == 0);
            hi_walk_off = ($urandom_range(0, 5) == 0);
            host_ext_en = 1'($urandom);
            lo_tag_ign = 1'($urandom); hi_tag_ign = 1'($urandom);
            lo_tag_fetch_off = 1'($urandom); hi_tag_fetch_off = 1'($urandom);
            lva_cap = 1'($urandom);
            step(($urandom_range(0, 3) != 0), "RND");
        end

        finish_run();
    end

endmodule